// File: doc/BRIEF.md
# Branch-Folding Predecoded Instruction Cache

This block is a small direct-mapped instruction store for a fetch unit. Each line keeps one instruction together with the address that fetch should use next. When a line is refilled, the refill port also says what follows that instruction: more straight-line code, an unconditional jump, a conditional branch, or a jump-and-link. It gives the transfer target as well. The block then writes the target into the line's next-address field. A lookup therefore hands the fetch unit its next address at once, and the control transfer never takes a fetch slot or a delay slot of its own.

Conditional branches are folded on the assumption that they are taken. The line keeps the fall-through address, which is the address of the branch plus 4. When the fetch response is a folded branch, that address is latched. If the branch then resolves not-taken, the block raises a redirect in the next cycle that carries the latched address. The fetch unit squashes the target instruction it already fetched and restarts there. A folded jump-and-link still has to write its return address to the register file. When that write meets an ordinary register write in the same cycle, the block stalls for one cycle and issues the link write one cycle later.

Top module: `fold_icache`

## Requirements
- R1: After reset every line is invalid: a lookup reports a miss, and redirectValid, linkWe and stall are 0.
- R2: A lookup is registered. The response appears on the clock edge that follows fetchEn, with rspValid=1. When the index and tag match a valid line, it returns rspHit=1 and the stored instruction. For a line refilled with kind 2'b00 (sequential), rspNext is the line address plus 4.
- R3: For a line refilled with kind 2'b01 (jump), rspNext equals the refill target, and rspFolded and rspLink are both 0.
- R4: For a line refilled with kind 2'b10 (conditional branch), rspNext equals the refill target and rspFolded=1.
- R5: A resolve marked not-taken that follows a folded-branch response sets redirectValid=1 for exactly one cycle, on the next clock edge. redirectPc then equals the line address plus 8, which is the branch address plus 4.
- R6: A resolve marked taken produces no redirect, and neither does a resolve that arrives when no folded branch is pending.
- R7: For a line refilled with kind 2'b11 (jump-and-link), rspNext equals the target and rspLink=1. When regWriteEn is 0 in the response cycle, linkWe=1 in that cycle with linkData equal to the line address plus 8.
- R8: When a link write and regWriteEn=1 fall in the same cycle, stall=1 and linkWe=0. In the following cycle linkWe=1, with the same return address.
- R9: A lookup whose tag differs from the stored tag at that index reports rspHit=0, rspFolded=0 and rspLink=0.
- R10: A refill and a lookup of the same address in the same cycle return the newly written instruction and next address.
- R11: A refill of an already valid line replaces all of its contents, including the fold kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refillEn | input | 1 | Write one line this cycle |
| refillPc | input | ADDR_W | Byte address of the refilled instruction |
| refillInstr | input | INSTR_W | Instruction word to store |
| refillKind | input | 2 | What follows: 00 sequential, 01 jump, 10 branch, 11 jump-and-link |
| refillTarget | input | ADDR_W | Target of the following transfer |
| fetchEn | input | 1 | Look up fetchPc this cycle |
| fetchPc | input | ADDR_W | Byte address to look up |
| rspValid | output | 1 | A response is present this cycle |
| rspHit | output | 1 | The response matched a valid line |
| rspInstr | output | INSTR_W | Stored instruction |
| rspNext | output | ADDR_W | Next fetch address |
| rspFolded | output | 1 | The line carries a predicted-taken branch |
| rspLink | output | 1 | The line carries a jump-and-link |
| resolveValid | input | 1 | The pending folded branch resolves this cycle |
| resolveTaken | input | 1 | Resolution outcome |
| redirectValid | output | 1 | Squash the target instruction and restart |
| redirectPc | output | ADDR_W | Restart address (fall-through) |
| regWriteEn | input | 1 | An ordinary register write uses the port this cycle |
| linkWe | output | 1 | Return-address write this cycle |
| linkData | output | ADDR_W | Return address |
| stall | output | 1 | Link write deferred; hold the pipeline one cycle |

## Verification
If a line stored the wrong fold kind or target, the fault shows in rspNext, rspFolded or rspLink one cycle after the lookup. If the latched fall-through address were corrupt or lost, the error would stay hidden until a not-taken resolve. It would then appear on redirectPc, or as a missing redirect, one cycle after that resolve. A bad deferral state shows on linkWe and stall either in the response cycle or in the cycle after it. The bench therefore sweeps every index with each fold kind, then drives the resolve and write-conflict sequences.

// File: rtl/fold_pkg.sv
package fold_pkg;

  typedef enum logic [1:0] {
    FOLLOW_SEQ    = 2'b00,
    FOLLOW_JUMP   = 2'b01,
    FOLLOW_BRANCH = 2'b10,
    FOLLOW_CALL   = 2'b11
  } followKind_e;

  typedef struct packed {
    logic writeLine;
    logic readLine;
    logic useBypass;
    logic loadFall;
    logic loadRedirect;
    logic holdLink;
    logic selDefer;
  } foldStrobe_t;

endpackage

// File: rtl/fold_dp.sv
module fold_dp
  import fold_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int INDEX_W = 3,
  parameter int INSTR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  foldStrobe_t        strobe,
  input  logic [ADDR_W-1:0]  refillPc,
  input  logic [INSTR_W-1:0] refillInstr,
  input  followKind_e        refillKind,
  input  logic [ADDR_W-1:0]  refillTarget,
  input  logic [ADDR_W-1:0]  fetchPc,
  output logic               sameIdx,
  output logic               readBranch,
  output logic               rspValid,
  output logic               rspHit,
  output logic [INSTR_W-1:0] rspInstr,
  output logic [ADDR_W-1:0]  rspNext,
  output logic               rspFolded,
  output logic               rspLink,
  output logic [ADDR_W-1:0]  rspLinkAddr,
  output logic [ADDR_W-1:0]  redirectPc,
  output logic [ADDR_W-1:0]  linkData
);

  localparam int TAG_W = ADDR_W - INDEX_W - 2;
  localparam int LINES = 1 << INDEX_W;

  logic [LINES-1:0]   validQ;
  logic [TAG_W-1:0]   tagQ   [LINES];
  logic [INSTR_W-1:0] instrQ [LINES];
  logic [ADDR_W-1:0]  nextQ  [LINES];
  logic [ADDR_W-1:0]  altQ   [LINES];
  logic [LINES-1:0]   brQ;
  logic [LINES-1:0]   linkQ;

  logic [INDEX_W-1:0] wrIdx, rdIdx;
  logic [TAG_W-1:0]   wrTag, rdTag;
  logic [ADDR_W-1:0]  newNext, newAlt;
  logic               newBr, newLink;

  logic               selValid, selBr, selLink, selHit;
  logic [TAG_W-1:0]   selTag;
  logic [INSTR_W-1:0] selInstr;
  logic [ADDR_W-1:0]  selNext, selAlt;

  logic [ADDR_W-1:0]  fallQ, deferQ;
  logic               unusedLowBits;

  assign unusedLowBits = ^{refillPc[1:0], fetchPc[1:0]};

  assign wrIdx = refillPc[INDEX_W+1:2];
  assign wrTag = refillPc[ADDR_W-1:INDEX_W+2];
  assign rdIdx = fetchPc[INDEX_W+1:2];
  assign rdTag = fetchPc[ADDR_W-1:INDEX_W+2];
  assign sameIdx = (wrIdx == rdIdx);

  // Line contents computed from the refill request
  always_comb begin
    newNext = (refillKind == FOLLOW_SEQ) ? refillPc + ADDR_W'(4) : refillTarget;
    newAlt  = refillPc + ADDR_W'(8);
    newBr   = (refillKind == FOLLOW_BRANCH);
    newLink = (refillKind == FOLLOW_CALL);
  end

  // Storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      brQ    <= '0;
      linkQ  <= '0;
    end else if (strobe.writeLine) begin
      validQ[wrIdx] <= 1'b1;
      brQ[wrIdx]    <= newBr;
      linkQ[wrIdx]  <= newLink;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.writeLine) begin
      tagQ[wrIdx]   <= wrTag;
      instrQ[wrIdx] <= refillInstr;
      nextQ[wrIdx]  <= newNext;
      altQ[wrIdx]   <= newAlt;
    end
  end

  // Read select with same-cycle refill forwarding
  always_comb begin
    if (strobe.useBypass) begin
      selValid = 1'b1;
      selTag   = wrTag;
      selInstr = refillInstr;
      selNext  = newNext;
      selAlt   = newAlt;
      selBr    = newBr;
      selLink  = newLink;
    end else begin
      selValid = validQ[rdIdx];
      selTag   = tagQ[rdIdx];
      selInstr = instrQ[rdIdx];
      selNext  = nextQ[rdIdx];
      selAlt   = altQ[rdIdx];
      selBr    = brQ[rdIdx];
      selLink  = linkQ[rdIdx];
    end
    selHit = selValid && (selTag == rdTag);
  end

  assign readBranch = selHit && selBr;

  // Response and side registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspHit      <= 1'b0;
      rspInstr    <= '0;
      rspNext     <= '0;
      rspFolded   <= 1'b0;
      rspLink     <= 1'b0;
      rspLinkAddr <= '0;
      fallQ       <= '0;
      redirectPc  <= '0;
      deferQ      <= '0;
    end else begin
      rspValid  <= strobe.readLine;
      rspHit    <= strobe.readLine && selHit;
      rspFolded <= strobe.readLine && selHit && selBr;
      rspLink   <= strobe.readLine && selHit && selLink;
      if (strobe.readLine) begin
        rspInstr    <= selInstr;
        rspNext     <= selNext;
        rspLinkAddr <= selAlt;
      end
      if (strobe.loadFall)     fallQ      <= selAlt;
      if (strobe.loadRedirect) redirectPc <= fallQ;
      if (strobe.holdLink)     deferQ     <= rspLinkAddr;
    end
  end

  assign linkData = strobe.selDefer ? deferQ : rspLinkAddr;

endmodule

// File: rtl/fold_ctl.sv
module fold_ctl
  import fold_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        refillEn,
  input  logic        fetchEn,
  input  logic        sameIdx,
  input  logic        readBranch,
  input  logic        rspLink,
  input  logic        regWriteEn,
  input  logic        resolveValid,
  input  logic        resolveTaken,
  output foldStrobe_t strobe,
  output logic        redirectValid,
  output logic        linkWe,
  output logic        stall
);

  logic pendQ;
  logic deferQ;
  logic mispredict;
  logic deferNow;

  assign mispredict = resolveValid && !resolveTaken && pendQ;
  assign deferNow   = rspLink && (regWriteEn || deferQ);

  always_comb begin
    strobe              = '0;
    strobe.writeLine    = refillEn;
    strobe.readLine     = fetchEn;
    strobe.useBypass    = refillEn && fetchEn && sameIdx;
    strobe.loadFall     = fetchEn && readBranch;
    strobe.loadRedirect = mispredict;
    strobe.holdLink     = deferNow;
    strobe.selDefer     = deferQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ         <= 1'b0;
      deferQ        <= 1'b0;
      redirectValid <= 1'b0;
    end else begin
      if (fetchEn && readBranch) pendQ <= 1'b1;
      else if (resolveValid)     pendQ <= 1'b0;
      deferQ        <= deferNow;
      redirectValid <= mispredict;
    end
  end

  assign linkWe = deferQ || (rspLink && !regWriteEn);
  assign stall  = deferNow;

endmodule

// File: rtl/fold_icache.sv
module fold_icache
  import fold_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int INDEX_W = 3,
  parameter int INSTR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refillEn,
  input  logic [ADDR_W-1:0]  refillPc,
  input  logic [INSTR_W-1:0] refillInstr,
  input  logic [1:0]         refillKind,
  input  logic [ADDR_W-1:0]  refillTarget,
  input  logic               fetchEn,
  input  logic [ADDR_W-1:0]  fetchPc,
  output logic               rspValid,
  output logic               rspHit,
  output logic [INSTR_W-1:0] rspInstr,
  output logic [ADDR_W-1:0]  rspNext,
  output logic               rspFolded,
  output logic               rspLink,
  input  logic               resolveValid,
  input  logic               resolveTaken,
  output logic               redirectValid,
  output logic [ADDR_W-1:0]  redirectPc,
  input  logic               regWriteEn,
  output logic               linkWe,
  output logic [ADDR_W-1:0]  linkData,
  output logic               stall
);

  foldStrobe_t       strobe;
  logic              sameIdx;
  logic              readBranch;
  logic [ADDR_W-1:0] rspLinkAddr;

  fold_ctl u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .refillEn     (refillEn),
    .fetchEn      (fetchEn),
    .sameIdx      (sameIdx),
    .readBranch   (readBranch),
    .rspLink      (rspLink),
    .regWriteEn   (regWriteEn),
    .resolveValid (resolveValid),
    .resolveTaken (resolveTaken),
    .strobe       (strobe),
    .redirectValid(redirectValid),
    .linkWe       (linkWe),
    .stall        (stall)
  );

  fold_dp #(
    .ADDR_W (ADDR_W),
    .INDEX_W(INDEX_W),
    .INSTR_W(INSTR_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .refillPc    (refillPc),
    .refillInstr (refillInstr),
    .refillKind  (followKind_e'(refillKind)),
    .refillTarget(refillTarget),
    .fetchPc     (fetchPc),
    .sameIdx     (sameIdx),
    .readBranch  (readBranch),
    .rspValid    (rspValid),
    .rspHit      (rspHit),
    .rspInstr    (rspInstr),
    .rspNext     (rspNext),
    .rspFolded   (rspFolded),
    .rspLink     (rspLink),
    .rspLinkAddr (rspLinkAddr),
    .redirectPc  (redirectPc),
    .linkData    (linkData)
  );

endmodule

// File: rtl/fold_icache_chk.sv
module fold_icache_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              fetchEn,
  input logic              rspValid,
  input logic              rspHit,
  input logic              rspFolded,
  input logic              rspLink,
  input logic              resolveValid,
  input logic              resolveTaken,
  input logic              redirectValid,
  input logic              regWriteEn,
  input logic              linkWe,
  input logic [ADDR_W-1:0] linkData,
  input logic [ADDR_W-1:0] rspLinkAddr,
  input logic              stall
);

  AST_RSP_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(fetchEn)); // R2

  AST_MISS_NO_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    !rspHit |-> (!rspFolded && !rspLink)); // R9

  AST_REDIRECT_NEEDS_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> $past(resolveValid && !resolveTaken)); // R5

  AST_TAKEN_NO_REDIRECT: assert property (@(posedge clk) disable iff (!rstN)
    (resolveValid && resolveTaken) |=> !redirectValid); // R6

  AST_STALL_DEFERS_LINK: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> (linkWe && linkData == $past(rspLinkAddr))); // R8

  AST_LINK_FREE_PORT: assert property (@(posedge clk) disable iff (!rstN)
    (rspLink && !regWriteEn && !stall) |-> linkWe); // R7

endmodule

bind fold_icache fold_icache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .fetchEn      (fetchEn),
  .rspValid     (rspValid),
  .rspHit       (rspHit),
  .rspFolded    (rspFolded),
  .rspLink      (rspLink),
  .resolveValid (resolveValid),
  .resolveTaken (resolveTaken),
  .redirectValid(redirectValid),
  .regWriteEn   (regWriteEn),
  .linkWe       (linkWe),
  .linkData     (linkData),
  .rspLinkAddr  (rspLinkAddr),
  .stall        (stall)
);

// File: tb/tb_fold_icache.sv
`timescale 1ns/100ps
module tb_fold_icache;

  localparam int ADDR_W  = 16;
  localparam int INDEX_W = 3;
  localparam int INSTR_W = 32;
  localparam int LINES   = 1 << INDEX_W;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               refillEn = 1'b0;
  logic [ADDR_W-1:0]  refillPc = '0;
  logic [INSTR_W-1:0] refillInstr = '0;
  logic [1:0]         refillKind = '0;
  logic [ADDR_W-1:0]  refillTarget = '0;
  logic               fetchEn = 1'b0;
  logic [ADDR_W-1:0]  fetchPc = '0;
  logic               rspValid, rspHit, rspFolded, rspLink;
  logic [INSTR_W-1:0] rspInstr;
  logic [ADDR_W-1:0]  rspNext;
  logic               resolveValid = 1'b0;
  logic               resolveTaken = 1'b0;
  logic               redirectValid;
  logic [ADDR_W-1:0]  redirectPc;
  logic               regWriteEn = 1'b0;
  logic               linkWe;
  logic [ADDR_W-1:0]  linkData;
  logic               stall;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  fold_icache #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .INSTR_W(INSTR_W)) dut (
    .clk(clk), .rstN(rstN),
    .refillEn(refillEn), .refillPc(refillPc), .refillInstr(refillInstr),
    .refillKind(refillKind), .refillTarget(refillTarget),
    .fetchEn(fetchEn), .fetchPc(fetchPc),
    .rspValid(rspValid), .rspHit(rspHit), .rspInstr(rspInstr), .rspNext(rspNext),
    .rspFolded(rspFolded), .rspLink(rspLink),
    .resolveValid(resolveValid), .resolveTaken(resolveTaken),
    .redirectValid(redirectValid), .redirectPc(redirectPc),
    .regWriteEn(regWriteEn), .linkWe(linkWe), .linkData(linkData), .stall(stall)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [ADDR_W-1:0] mkPc(input int tag, input int idx);
    return ADDR_W'((tag << (INDEX_W + 2)) | (idx << 2));
  endfunction

  task automatic doRefill(input logic [ADDR_W-1:0] pc, input logic [INSTR_W-1:0] ins,
                          input logic [1:0] kind, input logic [ADDR_W-1:0] tgt);
    refillEn = 1'b1; refillPc = pc; refillInstr = ins; refillKind = kind; refillTarget = tgt;
    step();
    refillEn = 1'b0;
  endtask

  task automatic doFetch(input logic [ADDR_W-1:0] pc);
    fetchEn = 1'b1; fetchPc = pc;
    step();
    fetchEn = 1'b0;
  endtask

  initial begin
    #500000;
    if (!finished) begin
      finished = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] pc, tgt;
    int kind;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    step();

    // R1: reset state
    doFetch(mkPc(5, 0));
    chk(rspValid && !rspHit, "R1 miss after reset", rspHit, 0);
    chk(!redirectValid && !linkWe && !stall, "R1 quiet outputs",
        {redirectValid, linkWe, stall}, 0);

    // Sweep every index with kind = idx mod 4
    for (int i = 0; i < LINES; i++)
      doRefill(mkPc(5, i), 32'hA000_0000 + i, 2'(i % 4), ADDR_W'(16'h8000 + i * 64));
    for (int i = 0; i < LINES; i++) begin
      pc = mkPc(5, i);
      tgt = ADDR_W'(16'h8000 + i * 64);
      kind = i % 4;
      doFetch(pc);
      chk(rspValid && rspHit && rspInstr == 32'hA000_0000 + i, "R2 hit and instruction",
          rspInstr, 32'hA000_0000 + i);
      case (kind)
        0: chk(rspNext == pc + 4 && !rspFolded && !rspLink, "R2 sequential next",
               rspNext, pc + 4);
        1: chk(rspNext == tgt && !rspFolded && !rspLink, "R3 jump folded", rspNext, tgt);
        2: chk(rspNext == tgt && rspFolded && !rspLink, "R4 branch folded", rspNext, tgt);
        default: begin
          chk(rspNext == tgt && rspLink && !rspFolded, "R7 call folded", rspNext, tgt);
          chk(linkWe && !stall && linkData == pc + 8, "R7 link write", linkData, pc + 8);
        end
      endcase
    end

    // R9: tag mismatch
    for (int i = 0; i < LINES; i++) begin
      doFetch(mkPc(9, i));
      chk(rspValid && !rspHit && !rspFolded && !rspLink, "R9 tag miss",
          {rspHit, rspFolded, rspLink}, 0);
    end

    // R5: mispredict redirect
    pc = mkPc(5, 2);
    doFetch(pc);
    resolveValid = 1'b1; resolveTaken = 1'b0;
    step();
    resolveValid = 1'b0;
    chk(redirectValid && redirectPc == pc + 8, "R5 redirect to fall-through", redirectPc, pc + 8);
    step();
    chk(!redirectValid, "R5 redirect one cycle", redirectValid, 0);

    // R6: taken resolve, then resolve with nothing pending
    doFetch(mkPc(5, 6));
    resolveValid = 1'b1; resolveTaken = 1'b1;
    step();
    chk(!redirectValid, "R6 taken no redirect", redirectValid, 0);
    resolveTaken = 1'b0;
    step();
    resolveValid = 1'b0;
    chk(!redirectValid, "R6 nothing pending", redirectValid, 0);

    // R8: link write conflict
    pc = mkPc(5, 3);
    doFetch(pc);
    regWriteEn = 1'b1;
    #1;
    chk(stall && !linkWe, "R8 stall on conflict", {stall, linkWe}, 2);
    step();
    regWriteEn = 1'b0;
    #1;
    chk(linkWe && !stall && linkData == pc + 8, "R8 deferred link", linkData, pc + 8);
    step();
    chk(!linkWe && !stall, "R8 link once", linkWe, 0);

    // R10: same-cycle refill and lookup
    pc = mkPc(5, 5);
    refillEn = 1'b1; refillPc = pc; refillInstr = 32'hBEEF_0005;
    refillKind = 2'b01; refillTarget = 16'h1230;
    fetchEn = 1'b1; fetchPc = pc;
    step();
    refillEn = 1'b0; fetchEn = 1'b0;
    chk(rspHit && rspInstr == 32'hBEEF_0005 && rspNext == 16'h1230, "R10 forwarded",
        rspInstr, 32'hBEEF_0005);

    // R11: overwrite a branch line with a sequential one
    pc = mkPc(5, 2);
    doRefill(pc, 32'hC0DE_0002, 2'b00, 16'h7770);
    doFetch(pc);
    chk(rspHit && rspInstr == 32'hC0DE_0002 && rspNext == pc + 4 && !rspFolded,
        "R11 overwrite", rspNext, pc + 4);
    resolveValid = 1'b1; resolveTaken = 1'b0;
    step();
    resolveValid = 1'b0;
    chk(!redirectValid, "R11 no pending from overwritten line", redirectValid, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule